// File: doc/BRIEF.md
# DDR3 Refresh and Write-Recovery Timing Calculator

This block turns a DRAM clock frequency, given in whole MHz, and a device-density code into the three timing values that a DDR3 controller needs at bring-up. The first is the refresh cycle time in clocks. The second is the average refresh interval in clocks. The third is the 3-bit write-recovery code for mode register 0. A one-cycle `start` pulse captures the frequency and the density. The block then works through the three values one after another on a single shared multiplier and a bit-serial divide-by-1000.

When all three outputs are final it raises `valid`. It holds the results until the next `start`. A `start` that arrives in the middle of a computation drops the work in progress and begins again with the new inputs. Loading the results into controller registers and sending mode-register commands are left to the logic around this block.

Top module: `ddr_timing_calc`

## Requirements
- R1: With density code 0, 1, 2, 3, 4 or 5, the refresh cycle time in nanoseconds is 90, 90, 110, 160, 300 or 350 respectively. `trfcCk` equals floor((ns * clkMhz + 999) / 1000), which is the nanosecond value rounded up to whole clocks.
- R2: `trefiCk` equals floor(7987 * clkMhz / 1024). This keeps the refresh interval at or below 7.8 us.
- R3: Let twr = floor((15 * clkMhz + 999) / 1000). `wrCode` is then 1 when twr < 5, twr - 4 when twr is 5 to 8, 5 when twr is 9 or 10, and 6 when twr is 11 or more.
- R4: Density codes 6 and 7 give the same refresh cycle time as code 0 (90 ns).
- R5: While `rstN` is low, and after it is released until the first `start`, `valid` is 0 and `trfcCk`, `trefiCk` and `wrCode` are 0.
- R6: `valid` is 0 in the cycle after any `start` is sampled. While `valid` is 1 and `start` is 0, `valid` and all three results keep their values.
- R7: A `start` sampled while a computation is under way abandons that computation. The results and their timing then follow the newest `start` only.
- R8: `valid` rises exactly 2*DIV_W+8 rising clock edges after the edge that samples `start`. With the default DIV_W=20 this is 48 edges.
- R9: `clkMhz` and `density` are used only as sampled on the `start` edge. Changing them afterwards does not alter the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that samples the inputs and begins a computation |
| clkMhz | input | CLK_W (10) | DRAM clock frequency in MHz |
| density | input | 3 | Device density code, 0 = 256Mb up to 5 = 8Gb |
| trfcCk | output | TRFC_W (9) | Refresh cycle time in clocks |
| trefiCk | output | TREFI_W (13) | Refresh interval in clocks |
| wrCode | output | 3 | Write-recovery code for mode register 0 |
| valid | output | 1 | All three results are final |

## Verification
A bad density lookup shows up only in `trfcCk`. A bad multiplier operand select corrupts whichever result uses that phase. A divider that drops or adds a step moves both `trfcCk` and `wrCode` by about a factor of two, and it also shifts the rise of `valid` by whole cycles. The sequencer's state is visible only through when `valid` rises, so the exact rise edge is checked on every run. That check catches a skipped or repeated phase on the first computation after reset. A restart, or an input change after `start`, that leaks into the datapath appears as wrong values at the next `valid`.

// File: rtl/ddr_timing_pkg.sv
package ddr_timing_pkg;

  localparam int OPA_W      = 13;    // widest constant multiplicand (7987)
  localparam int DEN_W      = 10;    // divisor 1000 fits in 10 bits
  localparam int DIVISOR    = 1000;
  localparam int ROUND_UP   = 999;
  localparam int REFI_MUL   = 7987;
  localparam int REFI_SHIFT = 10;
  localparam int TWR_NS     = 15;

  typedef enum logic [1:0] {
    OP_RFC  = 2'd0,
    OP_REFI = 2'd1,
    OP_WR   = 2'd2
  } opSel_e;

  typedef struct packed {
    logic   latchIn;
    logic   clrValid;
    logic   mulEn;
    opSel_e opSel;
    logic   divLoad;
    logic   divStep;
    logic   capRfc;
    logic   capRefi;
    logic   capWr;
  } strobe_t;

  function automatic logic [OPA_W-1:0] refreshNs(input logic [2:0] code);
    logic [OPA_W-1:0] ns;
    case (code)
      3'd1:    ns = OPA_W'(90);
      3'd2:    ns = OPA_W'(110);
      3'd3:    ns = OPA_W'(160);
      3'd4:    ns = OPA_W'(300);
      3'd5:    ns = OPA_W'(350);
      default: ns = OPA_W'(90);
    endcase
    return ns;
  endfunction

endpackage

// File: rtl/ddr_timing_ctrl.sv
module ddr_timing_ctrl
  import ddr_timing_pkg::*;
#(
  parameter int DIV_W = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t stb
);

  localparam int CNT_W = $clog2(DIV_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DIV_W - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_MUL_RFC, S_LD_RFC, S_DIV_RFC, S_CAP_RFC,
    S_MUL_REFI, S_CAP_REFI, S_MUL_WR, S_LD_WR, S_DIV_WR, S_CAP_WR
  } state_e;

  state_e state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateNext = state;
    stb = '0;
    stb.opSel = OP_RFC;
    if (start) begin
      stb.latchIn  = 1'b1;
      stb.clrValid = 1'b1;
      stateNext    = S_MUL_RFC;
    end else begin
      case (state)
        S_IDLE: stateNext = S_IDLE;
        S_MUL_RFC: begin
          stb.mulEn = 1'b1;
          stb.opSel = OP_RFC;
          stateNext = S_LD_RFC;
        end
        S_LD_RFC: begin
          stb.divLoad = 1'b1;
          stateNext   = S_DIV_RFC;
        end
        S_DIV_RFC: begin
          stb.divStep = 1'b1;
          if (stepCnt == LAST_STEP) stateNext = S_CAP_RFC;
        end
        S_CAP_RFC: begin
          stb.capRfc = 1'b1;
          stateNext  = S_MUL_REFI;
        end
        S_MUL_REFI: begin
          stb.mulEn = 1'b1;
          stb.opSel = OP_REFI;
          stateNext = S_CAP_REFI;
        end
        S_CAP_REFI: begin
          stb.capRefi = 1'b1;
          stateNext   = S_MUL_WR;
        end
        S_MUL_WR: begin
          stb.mulEn = 1'b1;
          stb.opSel = OP_WR;
          stateNext = S_LD_WR;
        end
        S_LD_WR: begin
          stb.divLoad = 1'b1;
          stateNext   = S_DIV_WR;
        end
        S_DIV_WR: begin
          stb.divStep = 1'b1;
          if (stepCnt == LAST_STEP) stateNext = S_CAP_WR;
        end
        S_CAP_WR: begin
          stb.capWr = 1'b1;
          stateNext = S_IDLE;
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (stb.divLoad || start) stepCnt <= '0;
      else if (stb.divStep)     stepCnt <= stepCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ddr_timing_dp.sv
module ddr_timing_dp
  import ddr_timing_pkg::*;
#(
  parameter int CLK_W   = 10,
  parameter int TRFC_W  = 9,
  parameter int TREFI_W = 13,
  parameter int DIV_W   = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [CLK_W-1:0]   clkMhz,
  input  logic [2:0]         density,
  output logic [TRFC_W-1:0]  trfcCk,
  output logic [TREFI_W-1:0] trefiCk,
  output logic [2:0]         wrCode,
  output logic               valid
);

  localparam int PROD_W = CLK_W + OPA_W;
  localparam logic [DEN_W:0] DIVISOR_V = (DEN_W+1)'(DIVISOR);

  logic [CLK_W-1:0]  clkReg;
  logic [2:0]        densReg;
  logic [OPA_W-1:0]  opA;
  logic [PROD_W-1:0] prodReg;
  logic [DEN_W-1:0]  remReg;
  logic [DIV_W-1:0]  quoReg;
  logic [DEN_W:0]    trial;
  logic              trialFits;
  logic [2:0]        wrNext;

  // shared multiplicand select
  always_comb begin
    case (stb.opSel)
      OP_REFI: opA = OPA_W'(REFI_MUL);
      OP_WR:   opA = OPA_W'(TWR_NS);
      default: opA = refreshNs(densReg);
    endcase
  end

  // restoring divide-by-1000 step, quotient shifts in behind the dividend
  assign trial     = {remReg, quoReg[DIV_W-1]};
  assign trialFits = (trial >= DIVISOR_V);

  // write-recovery encoding from the divided clock count
  always_comb begin
    if (quoReg < DIV_W'(5))       wrNext = 3'd1;
    else if (quoReg <= DIV_W'(8)) wrNext = 3'(quoReg - DIV_W'(4));
    else if (quoReg <= DIV_W'(10)) wrNext = 3'd5;
    else                           wrNext = 3'd6;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkReg  <= '0;
      densReg <= '0;
      prodReg <= '0;
      remReg  <= '0;
      quoReg  <= '0;
      trfcCk  <= '0;
      trefiCk <= '0;
      wrCode  <= '0;
      valid   <= 1'b0;
    end else begin
      if (stb.latchIn) begin
        clkReg  <= clkMhz;
        densReg <= density;
      end
      if (stb.mulEn)
        prodReg <= PROD_W'(opA) * PROD_W'(clkReg);
      if (stb.divLoad) begin
        remReg <= '0;
        quoReg <= DIV_W'(prodReg) + DIV_W'(ROUND_UP);
      end else if (stb.divStep) begin
        if (trialFits) begin
          remReg <= DEN_W'(trial - DIVISOR_V);
          quoReg <= {quoReg[DIV_W-2:0], 1'b1};
        end else begin
          remReg <= trial[DEN_W-1:0];
          quoReg <= {quoReg[DIV_W-2:0], 1'b0};
        end
      end
      if (stb.capRfc)  trfcCk  <= quoReg[TRFC_W-1:0];
      if (stb.capRefi) trefiCk <= TREFI_W'(prodReg >> REFI_SHIFT);
      if (stb.capWr)   wrCode  <= wrNext;
      if (stb.clrValid)   valid <= 1'b0;
      else if (stb.capWr) valid <= 1'b1;
    end
  end

endmodule

// File: rtl/ddr_timing_calc.sv
module ddr_timing_calc
  import ddr_timing_pkg::*;
#(
  parameter int CLK_W   = 10,
  parameter int TRFC_W  = 9,
  parameter int TREFI_W = 13,
  parameter int DIV_W   = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CLK_W-1:0]   clkMhz,
  input  logic [2:0]         density,
  output logic [TRFC_W-1:0]  trfcCk,
  output logic [TREFI_W-1:0] trefiCk,
  output logic [2:0]         wrCode,
  output logic               valid
);

  strobe_t stb;

  ddr_timing_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stb   (stb)
  );

  ddr_timing_dp #(
    .CLK_W   (CLK_W),
    .TRFC_W  (TRFC_W),
    .TREFI_W (TREFI_W),
    .DIV_W   (DIV_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .clkMhz  (clkMhz),
    .density (density),
    .trfcCk  (trfcCk),
    .trefiCk (trefiCk),
    .wrCode  (wrCode),
    .valid   (valid)
  );

endmodule

// File: rtl/ddr_timing_chk.sv
module ddr_timing_chk
  import ddr_timing_pkg::*;
#(
  parameter int CLK_W   = 10,
  parameter int TRFC_W  = 9,
  parameter int TREFI_W = 13,
  parameter int DIV_W   = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [CLK_W-1:0]   clkMhz,
  input logic [2:0]         density,
  input logic [TRFC_W-1:0]  trfcCk,
  input logic [TREFI_W-1:0] trefiCk,
  input logic [2:0]         wrCode,
  input logic               valid
);

  localparam int LAT = 2 * DIV_W + 8;
  localparam int CNT_W = $clog2(LAT + 4) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CLK_W-1:0] clkL;
  logic [2:0]       densL;
  logic [CNT_W-1:0] sinceStart;
  longint           nsProd, refiExp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkL       <= '0;
      densL      <= '0;
      sinceStart <= '0;
    end else if (start) begin
      clkL       <= clkMhz;
      densL      <= density;
      sinceStart <= CNT_W'(1);
    end else if (sinceStart != '0 && sinceStart != CNT_MAX) begin
      sinceStart <= sinceStart + CNT_W'(1);
    end
  end

  always_comb begin
    nsProd  = longint'(refreshNs(densL)) * longint'(clkL);
    refiExp = (longint'(REFI_MUL) * longint'(clkL)) >>> REFI_SHIFT;
  end

  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !start) |=> (valid && $stable(trfcCk) && $stable(trefiCk) && $stable(wrCode)));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(valid) |-> (int'(sinceStart) == LAT + 1));

  p_wr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (wrCode >= 3'd1 && wrCode <= 3'd6));

  p_refi_r2: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (longint'(trefiCk) == refiExp));

  p_rfc_ceil_r1: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (longint'(trfcCk) * 1000 >= nsProd &&
               longint'(trfcCk) * 1000 < nsProd + 1000));

endmodule

bind ddr_timing_calc ddr_timing_chk #(
  .CLK_W   (CLK_W),
  .TRFC_W  (TRFC_W),
  .TREFI_W (TREFI_W),
  .DIV_W   (DIV_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .clkMhz  (clkMhz),
  .density (density),
  .trfcCk  (trfcCk),
  .trefiCk (trefiCk),
  .wrCode  (wrCode),
  .valid   (valid)
);

// File: tb/tb_ddr_timing_calc.sv
module tb_ddr_timing_calc;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 20;
  localparam int LAT        = 2 * DIV_W + 8;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 12;

  typedef struct packed {
    logic [9:0]  fMhz;
    logic [2:0]  dens;
    logic [8:0]  expRfc;
    logic [12:0] expRefi;
    logic [2:0]  expWr;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{10'd400,  3'd3, 9'd64,  13'd3119, 3'd2},
    '{10'd533,  3'd4, 9'd160, 13'd4157, 3'd4},
    '{10'd300,  3'd0, 9'd27,  13'd2339, 3'd1},
    '{10'd200,  3'd1, 9'd18,  13'd1559, 3'd1},
    '{10'd666,  3'd5, 9'd234, 13'd5194, 3'd5},
    '{10'd1023, 3'd2, 9'd113, 13'd7979, 3'd6},
    '{10'd600,  3'd6, 9'd54,  13'd4679, 3'd5},
    '{10'd360,  3'd7, 9'd33,  13'd2807, 3'd2},
    '{10'd467,  3'd3, 9'd75,  13'd3642, 3'd4},
    '{10'd0,    3'd0, 9'd0,   13'd0,    3'd1},
    '{10'd333,  3'd0, 9'd30,  13'd2597, 3'd1},
    '{10'd667,  3'd5, 9'd234, 13'd5202, 3'd6}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  clkMhz = '0;
  logic [2:0]  density = '0;
  logic [8:0]  trfcCk;
  logic [12:0] trefiCk;
  logic [2:0]  wrCode;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_timing_calc dut (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .clkMhz  (clkMhz),
    .density (density),
    .trfcCk  (trfcCk),
    .trefiCk (trefiCk),
    .wrCode  (wrCode),
    .valid   (valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive a start pulse, then scramble the inputs (R9)
  task automatic launch(input logic [9:0] f, input logic [2:0] d);
    @(negedge clk);
    start = 1'b1; clkMhz = f; density = d;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; clkMhz = ~f; density = ~d;
    check(valid == 1'b0, "R6", "valid after start", int'(valid), 0);
  endtask

  // positioned at the negedge after the start edge
  task automatic awaitAndCheck(input vec_t v);
    string r1tag;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check(valid == 1'b0, "R8", "valid one edge early", int'(valid), 0);
    @(posedge clk);
    @(negedge clk);
    check(valid == 1'b1, "R8", "valid at latency", int'(valid), 1);
    r1tag = (v.dens >= 3'd6) ? "R4" : "R1";
    check(trfcCk == v.expRfc, r1tag, "trfcCk", int'(trfcCk), int'(v.expRfc));
    check(trefiCk == v.expRefi, "R2", "trefiCk", int'(trefiCk), int'(v.expRefi));
    check(wrCode == v.expWr, "R3", "wrCode", int'(wrCode), int'(v.expWr));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // R5: reset state, during and after reset
    repeat (3) @(negedge clk);
    check(valid == 1'b0 && trfcCk == '0 && trefiCk == '0 && wrCode == '0,
          "R5", "outputs in reset", int'(valid) + int'(trfcCk) + int'(wrCode), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(valid == 1'b0 && trfcCk == '0 && trefiCk == '0 && wrCode == '0,
          "R5", "outputs after reset", int'(valid) + int'(trfcCk) + int'(wrCode), 0);

    // vector table: R1, R2, R3, R4, R8, R9
    for (int i = 0; i < NVEC; i++) begin
      launch(VEC[i].fMhz, VEC[i].dens);
      awaitAndCheck(VEC[i]);
    end

    // R6: results and valid hold with no start while inputs wander
    clkMhz = 10'd55; density = 3'd2;
    repeat (6) @(negedge clk);
    check(valid == 1'b1, "R6", "valid hold", int'(valid), 1);
    check(trfcCk == VEC[NVEC-1].expRfc, "R6", "trfcCk hold",
          int'(trfcCk), int'(VEC[NVEC-1].expRfc));
    check(wrCode == VEC[NVEC-1].expWr, "R6", "wrCode hold",
          int'(wrCode), int'(VEC[NVEC-1].expWr));

    // R7: restart in the middle of a computation
    launch(VEC[0].fMhz, VEC[0].dens);
    repeat (10) @(negedge clk);
    check(valid == 1'b0, "R7", "valid while busy", int'(valid), 0);
    launch(VEC[5].fMhz, VEC[5].dens);
    awaitAndCheck(VEC[5]);

    // R7: restart during the second divide phase
    launch(VEC[2].fMhz, VEC[2].dens);
    repeat (LAT - 6) @(negedge clk);
    launch(VEC[4].fMhz, VEC[4].dens);
    awaitAndCheck(VEC[4]);

    // R5: a fresh reset clears the results again
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(valid == 1'b0 && trfcCk == '0 && trefiCk == '0 && wrCode == '0,
          "R5", "outputs after second reset", int'(valid) + int'(trfcCk), 0);
    rstN = 1'b1;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule